// File: doc/BRIEF.md
# Daisy-Chain SAR Converter Read Controller

This block sits on the host side of one or more 18-bit successive-approximation converters that share a serial bus, either as a single device selected by its convert line or as a daisy chain in which each device passes its neighbour's result through to the host. Working only from the system clock, it starts a conversion at a fixed interval, holds the convert strobe for a minimum width, waits out the worst-case conversion time, then generates a serial clock and gathers the returned bits into a shift register.

When the frame is complete, each device's 18-bit two's complement result is sign-extended to 32 bits and delivered on a parallel bus, one per clock with a valid strobe and a device index. Every timing quantity is given in system-clock counts through configuration inputs, and a configuration that breaks a converter minimum is flagged and blocks new conversions. A conversion start that falls due while a frame is still in progress is dropped and recorded in a sticky flag.

Top module: `sar_chain_reader`

## Requirements
- R1: While reset is asserted, `cnv`, `sck`, `res_valid` and `overrun` are 0 and `cfg_err` is 1.
- R2: `cfg_err` goes to 1 one clock after the configuration breaks a minimum (period below MIN_PERIOD, conversion wait below MIN_CONV_WAIT, half period below MIN_HALF_CS in select mode or MIN_HALF_CHAIN in chain mode, device count 0 or above MAX_DEV, or a count other than 1 in select mode); while it is 1 no conversion starts. It returns to 0 one clock after the configuration is legal again.
- R3: In select mode (`cfg_chain`=0) `cnv` is high for exactly CNV_HIGH_CLKS clocks. In chain mode (`cfg_chain`=1) `cnv` stays high from its rise and falls on the same clock edge as the final falling edge of `sck`.
- R4: `sdi` is 1 in select mode and 0 in chain mode, is unchanged over the clock in which `cnv` rises, and `sck` is low in that clock and in the clock before.
- R5: The first rising edge of `sck` comes exactly CNV_HIGH_CLKS + `cfg_conv_wait` + `cfg_sck_half` clocks after the rise of `cnv`.
- R6: Each frame has exactly 18 × `cfg_ndev` pulses of `sck`, every high phase and every low phase between pulses lasting `cfg_sck_half` clocks.
- R7: `sdo` is sampled on each clock edge where `sck` falls; bits are taken MSB first, and result k (k = 0 first) is the k-th group of 18 bits on the line, sign-extended from bit 17 to 32 bits.
- R8: After a frame, `res_valid` is high for exactly `cfg_ndev` consecutive clocks, with `res_idx` counting 0, 1, ... in those clocks.
- R9: With no overrun, consecutive rises of `cnv` are exactly `cfg_period` clocks apart.
- R10: A period tick that arrives while a frame is in progress sets `overrun`, which stays 1 until reset, and starts no conversion: the next rise of `cnv` comes a full period later (2 × `cfg_period` after the last one when the frame ends within two periods).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | 16 | Clocks between conversion starts |
| cfg_conv_wait | input | 16 | Clocks from end of convert pulse to start of readout |
| cfg_sck_half | input | 8 | Clocks per high or low phase of the serial clock |
| cfg_ndev | input | 3 | Number of devices in the chain |
| cfg_chain | input | 1 | 1 selects chain mode, 0 selects single-device select mode |
| cnv | output | 1 | Convert strobe to the converters |
| sck | output | 1 | Serial clock to the converters |
| sdi | output | 1 | Mode level for the first converter's serial input |
| sdo | input | 1 | Serial data from the chain |
| res_data | output | 32 | Sign-extended result |
| res_idx | output | 2 | Device index of the result, 0 nearest the host |
| res_valid | output | 1 | One-clock strobe per result |
| overrun | output | 1 | Sticky: a conversion start was skipped |
| cfg_err | output | 1 | Configuration breaks a converter minimum |

## Verification
A stuck or miscounting phase timer shows at once as a wrong convert width or a wrong delay from the convert rise to the first serial clock, visible in the first frame. A bit counter or snapshot of the device count that is off produces the wrong number of clock pulses and shifts every result by whole bits, so the returned words differ from the loaded pattern as soon as that frame's strobes appear. A broken overrun path is seen one period after a long frame starts, as a start that happens when it should be skipped, or as a flag that falls again.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int RES_BITS = 18;
    localparam int OUT_BITS = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CNV,
        ST_WAIT,
        ST_READ,
        ST_EMIT
    } rd_state_t;

    function automatic logic [OUT_BITS-1:0] sext_result(input logic [RES_BITS-1:0] v);
        return {{(OUT_BITS-RES_BITS){v[RES_BITS-1]}}, v};
    endfunction

endpackage

// File: rtl/sar_period_tick.sv
module sar_period_tick #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PER_W-1:0] period,
    output logic             tick
);

    logic [PER_W-1:0] cnt_d, cnt_q;
    logic             hit;

    always_comb begin
        hit   = en && (cnt_q >= period - PER_W'(1));
        cnt_d = cnt_q;
        if (!en || hit) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + PER_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick = hit;

    // R9: a tick is always followed by a restart of the count
    assert_tick_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/sar_cfg_check.sv
module sar_cfg_check #(
    parameter int PER_W          = 16,
    parameter int WAIT_W         = 16,
    parameter int HALF_W         = 8,
    parameter int DEV_W          = 3,
    parameter int MAX_DEV        = 4,
    parameter int MIN_PERIOD     = 400,
    parameter int MIN_CONV_WAIT  = 220,
    parameter int MIN_HALF_CS    = 1,
    parameter int MIN_HALF_CHAIN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  period,
    input  logic [WAIT_W-1:0] conv_wait,
    input  logic [HALF_W-1:0] sck_half,
    input  logic [DEV_W-1:0]  ndev,
    input  logic              chain,
    output logic              cfg_ok
);

    logic ok_d, ok_q;
    logic [HALF_W-1:0] half_min;

    always_comb begin
        half_min = chain ? HALF_W'(MIN_HALF_CHAIN) : HALF_W'(MIN_HALF_CS);
        ok_d = 1'b1;
        if (period < PER_W'(MIN_PERIOD))         ok_d = 1'b0;
        if (conv_wait < WAIT_W'(MIN_CONV_WAIT))  ok_d = 1'b0;
        if (sck_half < half_min)                 ok_d = 1'b0;
        if (ndev == '0)                          ok_d = 1'b0;
        if (ndev > DEV_W'(MAX_DEV))              ok_d = 1'b0;
        if (!chain && ndev != DEV_W'(1))         ok_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q <= 1'b0;
        end else begin
            ok_q <= ok_d;
        end
    end

    assign cfg_ok = ok_q;

endmodule

// File: rtl/sar_chain_reader.sv
module sar_chain_reader
    import sar_pkg::*;
#(
    parameter int MAX_DEV        = 4,
    parameter int PER_W          = 16,
    parameter int WAIT_W         = 16,
    parameter int HALF_W         = 8,
    parameter int CNV_HIGH_CLKS  = 2,
    parameter int MIN_PERIOD     = 400,
    parameter int MIN_CONV_WAIT  = 220,
    parameter int MIN_HALF_CS    = 1,
    parameter int MIN_HALF_CHAIN = 2,
    localparam int DEV_W = $clog2(MAX_DEV + 1),
    localparam int IDX_W = (MAX_DEV > 1) ? $clog2(MAX_DEV) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PER_W-1:0]    cfg_period,
    input  logic [WAIT_W-1:0]   cfg_conv_wait,
    input  logic [HALF_W-1:0]   cfg_sck_half,
    input  logic [DEV_W-1:0]    cfg_ndev,
    input  logic                cfg_chain,
    output logic                cnv,
    output logic                sck,
    output logic                sdi,
    input  logic                sdo,
    output logic [OUT_BITS-1:0] res_data,
    output logic [IDX_W-1:0]    res_idx,
    output logic                res_valid,
    output logic                overrun,
    output logic                cfg_err
);

    localparam int SH_W  = MAX_DEV * RES_BITS;
    localparam int BIT_W = $clog2(SH_W + 1);
    localparam int TMR_W = (WAIT_W > HALF_W) ? WAIT_W : HALF_W;

    typedef struct packed {
        rd_state_t           st;
        logic [TMR_W-1:0]    tmr;
        logic [BIT_W-1:0]    bits;
        logic [IDX_W-1:0]    k;
        logic                cnv;
        logic                sck;
        logic                mode;
        logic [DEV_W-1:0]    ndev;
        logic [HALF_W-1:0]   half;
        logic [SH_W-1:0]     sh;
        logic [OUT_BITS-1:0] data;
        logic [IDX_W-1:0]    idx;
        logic                vld;
        logic                ovr;
    } rd_regs_t;

    rd_regs_t r_d, r_q;
    logic     cfg_ok;
    logic     tick;
    logic [BIT_W-1:0] frame_bits;
    logic [BIT_W-1:0] slice_base;

    sar_cfg_check #(
        .PER_W(PER_W), .WAIT_W(WAIT_W), .HALF_W(HALF_W), .DEV_W(DEV_W),
        .MAX_DEV(MAX_DEV), .MIN_PERIOD(MIN_PERIOD), .MIN_CONV_WAIT(MIN_CONV_WAIT),
        .MIN_HALF_CS(MIN_HALF_CS), .MIN_HALF_CHAIN(MIN_HALF_CHAIN)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .period(cfg_period), .conv_wait(cfg_conv_wait),
        .sck_half(cfg_sck_half), .ndev(cfg_ndev), .chain(cfg_chain), .cfg_ok(cfg_ok)
    );

    sar_period_tick #(.PER_W(PER_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(cfg_ok), .period(cfg_period), .tick(tick)
    );

    always_comb begin
        r_d        = r_q;
        r_d.vld    = 1'b0;
        frame_bits = BIT_W'(r_q.ndev) * BIT_W'(RES_BITS);
        slice_base = (BIT_W'(r_q.ndev) - BIT_W'(1) - BIT_W'(r_q.k)) * BIT_W'(RES_BITS);

        if (tick && r_q.st != ST_IDLE) begin
            r_d.ovr = 1'b1;
        end

        case (r_q.st)
            ST_IDLE: begin
                r_d.cnv  = 1'b0;
                r_d.sck  = 1'b0;
                r_d.mode = cfg_chain;
                // start only when the mode level has been on sdi for a clock
                if (tick && (cfg_chain == r_q.mode)) begin
                    r_d.st   = ST_CNV;
                    r_d.cnv  = 1'b1;
                    r_d.tmr  = TMR_W'(CNV_HIGH_CLKS - 1);
                    r_d.ndev = cfg_ndev;
                    r_d.half = cfg_sck_half;
                end
            end
            ST_CNV: begin
                if (r_q.tmr == '0) begin
                    r_d.st  = ST_WAIT;
                    r_d.tmr = TMR_W'(cfg_conv_wait) - TMR_W'(1);
                    r_d.cnv = r_q.mode;
                end else begin
                    r_d.tmr = r_q.tmr - TMR_W'(1);
                end
            end
            ST_WAIT: begin
                if (r_q.tmr == '0) begin
                    r_d.st   = ST_READ;
                    r_d.tmr  = TMR_W'(r_q.half) - TMR_W'(1);
                    r_d.bits = '0;
                end else begin
                    r_d.tmr = r_q.tmr - TMR_W'(1);
                end
            end
            ST_READ: begin
                if (r_q.tmr == '0) begin
                    r_d.tmr = TMR_W'(r_q.half) - TMR_W'(1);
                    if (!r_q.sck) begin
                        r_d.sck = 1'b1;
                    end else begin
                        r_d.sck = 1'b0;
                        r_d.sh  = {r_q.sh[SH_W-2:0], sdo};
                        if (r_q.bits == frame_bits - BIT_W'(1)) begin
                            r_d.st  = ST_EMIT;
                            r_d.k   = '0;
                            r_d.cnv = 1'b0;
                        end else begin
                            r_d.bits = r_q.bits + BIT_W'(1);
                        end
                    end
                end else begin
                    r_d.tmr = r_q.tmr - TMR_W'(1);
                end
            end
            ST_EMIT: begin
                r_d.vld  = 1'b1;
                r_d.idx  = r_q.k;
                r_d.data = sext_result(r_q.sh[slice_base +: RES_BITS]);
                if (r_q.k == IDX_W'(r_q.ndev - DEV_W'(1))) begin
                    r_d.st = ST_IDLE;
                end else begin
                    r_d.k = r_q.k + IDX_W'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnv       = r_q.cnv;
    assign sck       = r_q.sck;
    assign sdi       = ~r_q.mode;
    assign res_data  = r_q.data;
    assign res_idx   = r_q.idx;
    assign res_valid = r_q.vld;
    assign overrun   = r_q.ovr;
    assign cfg_err   = ~cfg_ok;

    assert_no_start_on_bad_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv) |-> !$past(cfg_err));

    assert_cnv_min_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv) |=> cnv);

    assert_mode_pins_settled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv) |-> ($stable(sdi) && !sck && !$past(sck)));

    assert_sck_only_in_readout_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> (r_q.st == ST_READ));

    assert_first_result_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !$past(res_valid)) |-> (res_idx == '0));

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

endmodule

// File: tb/sar_chain_reader_tb.sv
module sar_chain_reader_tb;

    localparam int CNVH = 2;
    localparam int NV   = 4;

    localparam logic        TV_CHAIN [NV] = '{1'b0, 1'b1, 1'b1, 1'b0};
    localparam int          TV_NDEV  [NV] = '{1, 2, 4, 1};
    localparam int          TV_HALF  [NV] = '{1, 2, 3, 4};
    localparam logic [17:0] TV_W [NV*4] = '{
        18'h1FFFF, 18'h00000, 18'h00000, 18'h00000,
        18'h20000, 18'h00001, 18'h00000, 18'h00000,
        18'h3FFFF, 18'h15555, 18'h2AAAA, 18'h00000,
        18'h2ABCD, 18'h00000, 18'h00000, 18'h00000
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_period = 16'd1000;
    logic [15:0] cfg_conv_wait = 16'd300;
    logic [7:0]  cfg_sck_half = 8'd1;
    logic [2:0]  cfg_ndev = 3'd1;
    logic        cfg_chain = 1'b0;
    logic        cnv, sck, sdi, sdo;
    logic [31:0] res_data;
    logic [1:0]  res_idx;
    logic        res_valid, overrun, cfg_err;

    always #5 clk = ~clk;

    sar_chain_reader u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_conv_wait(cfg_conv_wait),
        .cfg_sck_half(cfg_sck_half), .cfg_ndev(cfg_ndev), .cfg_chain(cfg_chain),
        .cnv(cnv), .sck(sck), .sdi(sdi), .sdo(sdo), .res_data(res_data),
        .res_idx(res_idx), .res_valid(res_valid), .overrun(overrun), .cfg_err(cfg_err)
    );

    // converter chain model: loads words at convert rise, shifts on sck fall
    logic [17:0] adc_w [4];
    logic [71:0] frame = '0;
    logic        m_cnv_p = 1'b0, m_sck_p = 1'b0;
    assign sdo = frame[71];

    always @(negedge clk) begin
        if (cnv && !m_cnv_p) frame <= {adc_w[0], adc_w[1], adc_w[2], adc_w[3]};
        else if (!sck && m_sck_p) frame <= {frame[70:0], 1'b0};
        m_cnv_p <= cnv;
        m_sck_p <= sck;
    end

    // port monitor
    int cyc = 0, rise_cyc = 0, rise_count = 0, gap = 0, cnv_w = 0;
    int pulses = 0, first_dly = -1, sck_rise_cyc = 0, sck_fall_cyc = 0;
    int hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;
    int got_total = 0, vrun = 0, last_run = 0, idx_err = 0;
    logic sdi_at = 1'b0, sck_at = 1'b0, sck_before = 1'b0;
    logic mcnv_p = 1'b0, msck_p = 1'b0;
    logic [31:0] got_data [4];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (rst_n) begin
            if (cnv && !mcnv_p) begin
                gap = cyc - rise_cyc; rise_cyc = cyc; rise_count = rise_count + 1;
                pulses = 0; first_dly = -1; sdi_at = sdi; sck_at = sck; sck_before = msck_p;
                hi_min = 1000000; hi_max = 0; lo_min = 1000000; lo_max = 0;
            end
            if (!cnv && mcnv_p) cnv_w = cyc - rise_cyc;
            if (sck && !msck_p) begin
                pulses = pulses + 1;
                if (first_dly < 0) first_dly = cyc - rise_cyc;
                else begin
                    if (cyc - sck_fall_cyc < lo_min) lo_min = cyc - sck_fall_cyc;
                    if (cyc - sck_fall_cyc > lo_max) lo_max = cyc - sck_fall_cyc;
                end
                sck_rise_cyc = cyc;
            end
            if (!sck && msck_p) begin
                if (cyc - sck_rise_cyc < hi_min) hi_min = cyc - sck_rise_cyc;
                if (cyc - sck_rise_cyc > hi_max) hi_max = cyc - sck_rise_cyc;
                sck_fall_cyc = cyc;
            end
            if (res_valid) begin
                if (int'(res_idx) != vrun) idx_err = idx_err + 1;
                got_data[res_idx] = res_data;
                vrun = vrun + 1;
                got_total = got_total + 1;
            end else if (vrun > 0) begin
                last_run = vrun; vrun = 0;
            end
        end
        mcnv_p = cnv;
        msck_p = sck;
    end

    int total = 0, bad = 0;

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ext(input logic [17:0] v);
        return {{14{v[17]}}, v};
    endfunction

    task automatic set_cfg(input logic ch, input int nd, input int hf,
                           input int per, input int cw);
        cfg_chain = ch; cfg_ndev = 3'(nd); cfg_sck_half = 8'(hf);
        cfg_period = 16'(per); cfg_conv_wait = 16'(cw);
    endtask

    task automatic wait_results(input int base, input int nd);
        while (got_total < base + nd) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_frame(input logic ch, input int nd, input int hf,
                               input int cw, input int v);
        int bits;
        bits = 18 * nd;
        for (int j = 0; j < nd; j++)
            chk($sformatf("R7 data dev%0d vec%0d", j, v), got_data[j], ext(TV_W[v*4+j]));
        chk("R8 valid run length", last_run, nd);
        chk("R8 index order errors", idx_err, 0);
        chk("R4 sdi level at cnv rise", sdi_at, !ch);
        chk("R4 sck low around cnv rise", {sck_at, sck_before}, 0);
        chk("R5 cnv rise to first sck", first_dly, CNVH + cw + hf);
        chk("R6 sck pulse count", pulses, bits);
        chk("R6 high phase min/max", {hi_min[15:0], hi_max[15:0]}, {16'(hf), 16'(hf)});
        if (nd * 18 > 1)
            chk("R6 low phase min/max", {lo_min[15:0], lo_max[15:0]}, {16'(hf), 16'(hf)});
        if (ch) chk("R3 chain cnv width", cnv_w, CNVH + cw + 2 * hf * bits);
        else    chk("R3 select cnv width", cnv_w, CNVH);
    endtask

    task automatic run_all();
        int base, rc;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset cnv/sck/valid/overrun", {cnv, sck, res_valid, overrun}, 0);
        chk("R1 reset cfg_err", cfg_err, 1);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R2 cfg_err clear with legal cfg", cfg_err, 0);

        // table-driven frames
        for (int v = 0; v < NV; v++) begin
            set_cfg(TV_CHAIN[v], TV_NDEV[v], TV_HALF[v], 1000, 300);
            for (int j = 0; j < 4; j++) adc_w[j] = TV_W[v*4+j];
            base = got_total;
            rc   = rise_count;
            wait_results(base, TV_NDEV[v]);
            chk("R9 one conversion per frame", rise_count, rc + 1);
            check_frame(TV_CHAIN[v], TV_NDEV[v], TV_HALF[v], 300, v);
            if (rise_count >= 2) chk("R9 cnv rise spacing", gap, 1000);
            chk("R10 no overrun yet", overrun, 0);
        end

        // R10: period shorter than frame
        set_cfg(1'b1, 4, 2, 400, 300);
        for (int j = 0; j < 4; j++) adc_w[j] = TV_W[8+j];
        rc = rise_count;
        while (rise_count < rc + 2) @(negedge clk);
        chk("R10 skipped start gap", gap, 800);
        chk("R10 overrun set", overrun, 1);
        base = got_total;
        wait_results(base, 4);
        check_frame(1'b1, 4, 2, 300, 2);
        set_cfg(1'b1, 4, 2, 1000, 300);
        base = got_total;
        wait_results(base, 4);
        chk("R10 overrun sticky", overrun, 1);

        // R2: illegal configurations
        cfg_conv_wait = 16'd100;
        @(negedge clk); @(negedge clk);
        chk("R2 short conv wait flagged", cfg_err, 1);
        rc = rise_count;
        repeat (2500) @(negedge clk);
        chk("R2 no start while flagged", rise_count, rc);
        cfg_conv_wait = 16'd300;
        cfg_ndev = 3'd0;
        @(negedge clk); @(negedge clk);
        chk("R2 zero devices flagged", cfg_err, 1);
        set_cfg(1'b0, 2, 2, 1000, 300);
        @(negedge clk); @(negedge clk);
        chk("R2 select mode with two devices flagged", cfg_err, 1);
        set_cfg(1'b1, 4, 1, 1000, 300);
        @(negedge clk); @(negedge clk);
        chk("R2 chain half period too short flagged", cfg_err, 1);
        set_cfg(1'b0, 1, 1, 1000, 300);
        @(negedge clk); @(negedge clk);
        chk("R2 legal cfg clears flag", cfg_err, 0);
        for (int j = 0; j < 4; j++) adc_w[j] = TV_W[j];
        base = got_total;
        wait_results(base, 1);
        check_frame(1'b0, 1, 1, 300, 0);
    endtask

    initial begin
        bit wd;
        wd = 1'b0;
        for (int j = 0; j < 4; j++) adc_w[j] = TV_W[j];
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule